// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block keeps a last-in-first-out stack that lives in an external RAM and grows from the highest address downward. It holds the stack pointer and turns single-byte push and pop requests into RAM accesses. The pointer always names a free location. A push therefore writes at the pointer and then steps it down. A pop first steps the pointer up and then reads the byte found there. Every request takes one clock cycle. A popped byte comes back one cycle later, together with a single-cycle valid strobe.

The pointer can be reloaded at any time. A programmable lower bound marks where program memory begins. A push that writes below that bound is still carried out, but it raises a sticky overflow flag. A pop issued while the pointer sits at its initial value is refused and raises a sticky underflow flag. A push and a pop requested in the same cycle are both dropped, and a one-cycle collision pulse is raised.

Top module: `lifo_sp_unit`

## Requirements
- R1: After synchronous reset the pointer equals SP_INIT (all ones by default) and the lower bound equals BOUND_INIT (zero by default). The overflow flag, underflow flag, collision pulse, pop strobe and RAM write enable are all low.
- R2: A lone push drives mem_we high in the same cycle, with mem_addr equal to the current pointer and mem_wdata equal to push_data. On the next clock edge the pointer decreases by one.
- R3: A lone pop with the pointer not at SP_INIT keeps mem_we low and drives mem_addr to the pointer plus one in the same cycle. On the next clock edge the pointer increases by one. pop_valid is then high for exactly one cycle, and pop_data holds the byte that the RAM returned at that address.
- R4: Starting from the top of memory, pushing 52h and then 35h places 52h at the top address and 35h one below it, and leaves the pointer two below the top. Two pops that follow return 35h first and 52h second.
- R5: A push and a pop requested together, with no load, cause no RAM write and leave the pointer unchanged. clash_pulse is high for exactly the following cycle.
- R6: A lone pop while the pointer equals SP_INIT leaves the pointer unchanged and raises no pop_valid. It sets udf_flag, which stays set until a load or a reset.
- R7: A lone push whose write address is below the lower bound is still performed, in both the write and the decrement. It sets ovf_flag, which stays set across later pushes and pops until a load or a reset.
- R8: A load request takes priority over push and pop. In that cycle no RAM write occurs. On the next edge the pointer equals load_value, and both ovf_flag and udf_flag are cleared.
- R9: A bound write stores bound_value as the new lower bound, and that bound governs the pushes that follow it. A push whose write address equals the bound, or lies above it, does not set ovf_flag.
- R10: In a cycle with no request, mem_we is low and the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to store push_data on the stack |
| pop_req | input | 1 | Request to remove the top byte |
| push_data | input | DATA_W | Byte to store |
| load_req | input | 1 | Replace the pointer with load_value |
| load_value | input | ADDR_W | New pointer value |
| bound_wr | input | 1 | Store bound_value as the lower bound |
| bound_value | input | ADDR_W | Lowest address the stack may write without flagging |
| mem_addr | output | ADDR_W | RAM address for this cycle |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, asynchronous read of mem_addr |
| mem_we | output | 1 | RAM write enable |
| pop_data | output | DATA_W | Byte returned by the last pop |
| pop_valid | output | 1 | One-cycle strobe marking pop_data as fresh |
| sp_out | output | ADDR_W | Current stack pointer |
| ovf_flag | output | 1 | Sticky: a push wrote below the bound |
| udf_flag | output | 1 | Sticky: a pop was refused at the initial pointer |
| clash_pulse | output | 1 | One-cycle pulse after a rejected push/pop pair |

## Verification
The bench builds the block with a 10-bit address, an 8-bit data width and SP_INIT of 3FFh. This lets a 1024-byte behavioural RAM cover the whole address space, so the top-of-memory start, the refused pop at the initial pointer and the byte layout next to the top are all exercised on real RAM contents. A scoreboard replays the expected last-in-first-out order through interleaved push and pop bursts. The lower bound is placed next to the top, which brings both sides of the boundary within a few pushes: writing exactly at the bound and writing one below it.

// File: rtl/lifo_sp_pkg.sv
package lifo_sp_pkg;

    // Operation carried out in the current cycle, after arbitration.
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLASH = 3'd4,
        OP_UNDER = 3'd5
    } sp_op_e;

    // Fault indications kept by the unit.
    typedef struct packed {
        logic overflow;
        logic underflow;
        logic clash;
    } sp_fault_t;

    // Load wins; a simultaneous push/pop pair is rejected; a pop at the
    // initial pointer is demoted to an underflow.
    function automatic sp_op_e sp_classify(input logic ld,
                                           input logic psh,
                                           input logic pp,
                                           input logic at_top);
        sp_op_e op;
        if (ld)
            op = OP_LOAD;
        else if (psh && pp)
            op = OP_CLASH;
        else if (psh)
            op = OP_PUSH;
        else if (pp)
            op = at_top ? OP_UNDER : OP_POP;
        else
            op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/sp_cmd_decode.sv
module sp_cmd_decode
    import lifo_sp_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SP_INIT = '1
) (
    input  logic              load_req,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] bound,
    output sp_op_e            op,
    output logic              intrude
);

    logic at_top;

    always_comb begin
        at_top  = (sp == SP_INIT);
        intrude = (sp < bound);
        op      = sp_classify(load_req, push_req, pop_req, at_top);
    end

endmodule

// File: rtl/sp_pointer_reg.sv
module sp_pointer_reg
    import lifo_sp_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] SP_INIT    = '1,
    parameter logic [ADDR_W-1:0] BOUND_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  sp_op_e            op,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              bound_wr,
    input  logic [ADDR_W-1:0] bound_value,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] bound
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_INIT;
        end else begin
            case (op)
                OP_PUSH: sp <= sp - ONE;
                OP_POP:  sp <= sp + ONE;
                OP_LOAD: sp <= load_value;
                default: sp <= sp;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bound <= BOUND_INIT;
        else if (bound_wr)
            bound <= bound_value;
    end

endmodule

// File: rtl/sp_fault_flags.sv
module sp_fault_flags
    import lifo_sp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sp_op_e    op,
    input  logic      intrude,
    output sp_fault_t faults
);

    always_ff @(posedge clk) begin
        if (rst) begin
            faults <= '0;
        end else begin
            faults.clash <= (op == OP_CLASH);
            if (op == OP_LOAD) begin
                faults.overflow  <= 1'b0;
                faults.underflow <= 1'b0;
            end else begin
                if (op == OP_PUSH && intrude)
                    faults.overflow <= 1'b1;
                if (op == OP_UNDER)
                    faults.underflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sp_pop_capture.sv
module sp_pop_capture
    import lifo_sp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sp_op_e            op,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= (op == OP_POP);
            if (op == OP_POP)
                pop_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/lifo_sp_unit.sv
module lifo_sp_unit
    import lifo_sp_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 8,
    parameter logic [ADDR_W-1:0] SP_INIT    = '1,
    parameter logic [ADDR_W-1:0] BOUND_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              bound_wr,
    input  logic [ADDR_W-1:0] bound_value,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [ADDR_W-1:0] sp_out,
    output logic              ovf_flag,
    output logic              udf_flag,
    output logic              clash_pulse
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    sp_op_e            op;
    logic              intrude;
    logic [ADDR_W-1:0] sp;
    logic [ADDR_W-1:0] bound;
    sp_fault_t         faults;

    sp_cmd_decode #(
        .ADDR_W  (ADDR_W),
        .SP_INIT (SP_INIT)
    ) u_decode (
        .load_req (load_req),
        .push_req (push_req),
        .pop_req  (pop_req),
        .sp       (sp),
        .bound    (bound),
        .op       (op),
        .intrude  (intrude)
    );

    sp_pointer_reg #(
        .ADDR_W     (ADDR_W),
        .SP_INIT    (SP_INIT),
        .BOUND_INIT (BOUND_INIT)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .load_value  (load_value),
        .bound_wr    (bound_wr),
        .bound_value (bound_value),
        .sp          (sp),
        .bound       (bound)
    );

    sp_fault_flags u_faults (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .intrude (intrude),
        .faults  (faults)
    );

    sp_pop_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .mem_rdata (mem_rdata),
        .pop_data  (pop_data),
        .pop_valid (pop_valid)
    );

    // Push writes at the free slot; pop reads the slot just above it.
    always_comb begin
        mem_addr  = (op == OP_POP) ? (sp + ONE) : sp;
        mem_we    = (op == OP_PUSH);
        mem_wdata = push_data;
    end

    assign sp_out      = sp;
    assign ovf_flag    = faults.overflow;
    assign udf_flag    = faults.underflow;
    assign clash_pulse = faults.clash;

endmodule

// File: rtl/lifo_sp_checker.sv
module lifo_sp_checker #(
    parameter int unsigned       ADDR_W  = 16,
    parameter int unsigned       DATA_W  = 8,
    parameter logic [ADDR_W-1:0] SP_INIT = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              push_req,
    input logic              pop_req,
    input logic [DATA_W-1:0] push_data,
    input logic              load_req,
    input logic [ADDR_W-1:0] load_value,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] sp_out,
    input logic              ovf_flag,
    input logic              udf_flag,
    input logic              clash_pulse
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_push_access_R2: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !load_req) |->
            (mem_we && mem_addr == sp_out && mem_wdata == push_data));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !load_req) |=> (sp_out == $past(sp_out) - ONE));

    assert_pop_access_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !load_req && sp_out != SP_INIT) |->
            (!mem_we && mem_addr == sp_out + ONE));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !load_req && sp_out != SP_INIT) |=>
            (sp_out == $past(sp_out) + ONE && pop_valid));

    assert_pop_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(pop_req));

    assert_clash_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !load_req) |-> !mem_we);

    assert_clash_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !load_req) |=> (clash_pulse && $stable(sp_out)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !load_req && sp_out == SP_INIT) |=>
            (udf_flag && sp_out == SP_INIT && !pop_valid));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !load_req) |=> ovf_flag);

    assert_load_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        load_req |-> !mem_we);

    assert_load_value_R8: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (sp_out == $past(load_value) && !ovf_flag && !udf_flag));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!push_req && !pop_req && !load_req) |=> $stable(sp_out));

    assert_idle_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
        (!push_req && !pop_req && !load_req) |-> !mem_we);

endmodule

bind lifo_sp_unit lifo_sp_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SP_INIT (SP_INIT)
) u_lifo_chk (
    .clk         (clk),
    .rst         (rst),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .push_data   (push_data),
    .load_req    (load_req),
    .load_value  (load_value),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .pop_valid   (pop_valid),
    .sp_out      (sp_out),
    .ovf_flag    (ovf_flag),
    .udf_flag    (udf_flag),
    .clash_pulse (clash_pulse)
);

// File: tb/test_lifo_sp_unit.sv
`timescale 1ns/1ps
module test_lifo_sp_unit;

    localparam int unsigned       AW    = 10;
    localparam int unsigned       DW    = 8;
    localparam logic [AW-1:0]     TOP   = 10'h3FF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          load_req = 1'b0;
    logic [AW-1:0] load_value = '0;
    logic          bound_wr = 1'b0;
    logic [AW-1:0] bound_value = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic [DW-1:0] pop_data;
    logic          pop_valid;
    logic [AW-1:0] sp_out;
    logic          ovf_flag;
    logic          udf_flag;
    logic          clash_pulse;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic [DW-1:0] mstk [$];
    logic [DW-1:0] exp_q [$];
    logic [AW-1:0] model_sp;

    always #5 clk = ~clk;

    lifo_sp_unit #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .SP_INIT    (TOP),
        .BOUND_INIT ('0)
    ) i_lifo_sp_unit (
        .clk         (clk),
        .rst         (rst),
        .push_req    (push_req),
        .pop_req     (pop_req),
        .push_data   (push_data),
        .load_req    (load_req),
        .load_value  (load_value),
        .bound_wr    (bound_wr),
        .bound_value (bound_value),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_we      (mem_we),
        .pop_data    (pop_data),
        .pop_valid   (pop_valid),
        .sp_out      (sp_out),
        .ovf_flag    (ovf_flag),
        .udf_flag    (udf_flag),
        .clash_pulse (clash_pulse)
    );

    // Behavioural RAM: asynchronous read, write on the rising edge.
    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) begin
        if (mem_we)
            ram[mem_addr] <= mem_wdata;
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every pop strobe must match the oldest expected byte.
    always @(negedge clk) begin
        if (!rst && pop_valid) begin
            if (exp_q.size() == 0)
                check_eq("R3 unexpected pop strobe", 32'(pop_data), 32'hFFFF_FFFF);
            else
                check_eq("R3 scoreboard pop data", 32'(pop_data), 32'(exp_q.pop_front()));
        end
    end

    task automatic do_push(input logic [DW-1:0] d);
        @(negedge clk);
        push_req  = 1'b1;
        push_data = d;
        #1;
        check_eq("R2 write enable", 32'(mem_we), 32'd1);
        check_eq("R2 write address", 32'(mem_addr), 32'(model_sp));
        check_eq("R2 write data", 32'(mem_wdata), 32'(d));
        @(posedge clk);
        @(negedge clk);
        push_req = 1'b0;
        check_eq("R2 RAM content", 32'(ram[model_sp]), 32'(d));
        mstk.push_back(d);
        model_sp = model_sp - 10'd1;
        check_eq("R2 pointer after push", 32'(sp_out), 32'(model_sp));
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop_req = 1'b1;
        #1;
        check_eq("R3 read address", 32'(mem_addr), 32'(model_sp + 10'd1));
        check_eq("R3 no write on pop", 32'(mem_we), 32'd0);
        exp_q.push_back(mstk.pop_back());
        @(posedge clk);
        @(negedge clk);
        pop_req = 1'b0;
        model_sp = model_sp + 10'd1;
        check_eq("R3 pointer after pop", 32'(sp_out), 32'(model_sp));
        check_eq("R3 valid strobe", 32'(pop_valid), 32'd1);
    endtask

    task automatic do_load(input logic [AW-1:0] v, input logic with_push);
        @(negedge clk);
        load_req   = 1'b1;
        load_value = v;
        push_req   = with_push;
        push_data  = 8'hEE;
        #1;
        check_eq("R8 no write during load", 32'(mem_we), 32'd0);
        @(posedge clk);
        @(negedge clk);
        load_req = 1'b0;
        push_req = 1'b0;
        model_sp = v;
        mstk.delete();
        check_eq("R8 pointer loaded", 32'(sp_out), 32'(v));
        check_eq("R8 overflow cleared", 32'(ovf_flag), 32'd0);
        check_eq("R8 underflow cleared", 32'(udf_flag), 32'd0);
    endtask

    task automatic set_bound(input logic [AW-1:0] v);
        @(negedge clk);
        bound_wr    = 1'b1;
        bound_value = v;
        @(posedge clk);
        @(negedge clk);
        bound_wr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++)
            ram[i] = '0;
        model_sp = TOP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_eq("R1 pointer at reset", 32'(sp_out), 32'(TOP));
        check_eq("R1 overflow low", 32'(ovf_flag), 32'd0);
        check_eq("R1 underflow low", 32'(udf_flag), 32'd0);
        check_eq("R1 pop strobe low", 32'(pop_valid), 32'd0);
        check_eq("R1 clash low", 32'(clash_pulse), 32'd0);
        check_eq("R1 no write", 32'(mem_we), 32'd0);

        // R6 pop at the initial pointer is refused
        @(negedge clk);
        pop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pop_req = 1'b0;
        check_eq("R6 pointer unchanged", 32'(sp_out), 32'(TOP));
        check_eq("R6 underflow set", 32'(udf_flag), 32'd1);
        check_eq("R6 no pop strobe", 32'(pop_valid), 32'd0);
        @(negedge clk);
        check_eq("R6 underflow sticky", 32'(udf_flag), 32'd1);
        do_load(TOP, 1'b0);

        // R4 two-byte example from the top of memory
        do_push(8'h52);
        do_push(8'h35);
        check_eq("R4 top byte", 32'(ram[TOP]), 32'h52);
        check_eq("R4 next byte", 32'(ram[TOP - 10'd1]), 32'h35);
        check_eq("R4 pointer two below top", 32'(sp_out), 32'(TOP - 10'd2));
        do_pop();
        check_eq("R4 first pop", 32'(pop_data), 32'h35);
        do_pop();
        check_eq("R4 second pop", 32'(pop_data), 32'h52);
        @(negedge clk);
        check_eq("R3 strobe lasts one cycle", 32'(pop_valid), 32'd0);

        // Interleaved bursts through the scoreboard
        for (int i = 0; i < 8; i++)
            do_push(8'(i * 17 + 3));
        for (int i = 0; i < 3; i++)
            do_pop();
        do_push(8'hC3);
        do_push(8'h3C);
        while (mstk.size() > 0)
            do_pop();

        // R5 push and pop together
        do_push(8'hA5);
        @(negedge clk);
        push_req  = 1'b1;
        pop_req   = 1'b1;
        push_data = 8'h77;
        #1;
        check_eq("R5 no write on clash", 32'(mem_we), 32'd0);
        @(posedge clk);
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        check_eq("R5 clash pulse", 32'(clash_pulse), 32'd1);
        check_eq("R5 pointer unchanged", 32'(sp_out), 32'(model_sp));
        @(negedge clk);
        check_eq("R5 pulse one cycle", 32'(clash_pulse), 32'd0);
        do_pop();

        // R10 idle cycle
        @(negedge clk);
        #1;
        check_eq("R10 no write when idle", 32'(mem_we), 32'd0);
        @(negedge clk);
        check_eq("R10 pointer holds", 32'(sp_out), 32'(model_sp));

        // R7 / R9 lower bound next to the top
        set_bound(TOP - 10'd1);
        do_push(8'h01);
        check_eq("R9 above bound no flag", 32'(ovf_flag), 32'd0);
        do_push(8'h02);
        check_eq("R9 at bound no flag", 32'(ovf_flag), 32'd0);
        do_push(8'h03);
        check_eq("R7 below bound flags", 32'(ovf_flag), 32'd1);
        do_push(8'h04);
        check_eq("R7 flag stays", 32'(ovf_flag), 32'd1);
        while (mstk.size() > 0)
            do_pop();
        check_eq("R7 flag sticky over pops", 32'(ovf_flag), 32'd1);
        do_load(TOP, 1'b0);
        set_bound('0);

        // R8 load with a push in the same cycle
        do_load(10'h120, 1'b1);
        check_eq("R8 ignored push left RAM", 32'(ram[10'h120]), 32'h00);
        do_push(8'h11);
        do_push(8'h22);
        do_pop();
        do_pop();
        check_eq("R8 pointer back at loaded value", 32'(sp_out), 32'h120);

        repeat (2) @(negedge clk);
        check_eq("R3 all expected pops seen", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule